// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The block collects a bank of level-sensitive interrupt sources and folds them into a few combined request lines for a primary interrupt controller. The default build has 32 sources in four groups of eight. Each group drives its own output, and that output is high while any enabled source in the group is asserted. Each source passes through a synchronizer before it is used, so the sources may come from other clock domains.

Software sees one 32-bit register set on a simple synchronous bus. The enable bits are changed only through two strobe registers: one sets bits and one clears bits, and a 0 in the written data leaves the matching bit alone. No read-modify-write of a shared mask is needed. A read-only status register shows which sources are both asserted and enabled. Bit i of the status register belongs to source i. When a group output fires, the handler looks at that group's byte and serves the lowest set bit first.

Top module: `intgrp_combiner`

## Requirements
- R1: For the whole reset, and on the first clock after reset, all enable bits read 0, `irq_out` is all zeros and `bus_rdata` is 0.
- R2: A write (`bus_sel`=1, `bus_wr`=1) to byte offset 0x0 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: A write to byte offset 0x4 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A read (`bus_sel`=1, `bus_wr`=0) of offset 0x0 or 0x4 returns the enable register on `bus_rdata` in the following cycle.
- R5: A read of offset 0xC returns the status register in the following cycle. Bit i is 1 exactly when synchronized source i is high and enable bit i is 1.
- R6: Status is level-sensitive. When a source drops, its status bit and its group output fall again, and nothing is latched.
- R7: With the default 2-stage synchronizer, an `irq_in` change driven before clock edge k appears on `irq_out` after edge k+2. Output n is the OR of status bits [8n+7:8n].
- R8: A write to offset 0xC, or to any offset that is not 0x0 or 0x4, leaves the enable bits unchanged. A read of an unmapped offset returns 0. In a cycle that follows a cycle with no read, `bus_rdata` is 0.
- R9: Groups are independent. Enabled activity in one group's byte never raises the output of another group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus transfer request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| irq_out | output | 4 | Combined request line of each group |

## Verification
A corrupted enable bit shows up on the next read of offset 0x0, 0x4 or 0xC. While its source is asserted, it also shows up on that group's output within one cycle of the status change. A synchronizer or group register that is stuck or off by a stage moves the edge on `irq_out` away from edge k+2, so the bench checks that edge exactly. Decode faults, such as a status write that reaches the enables or a misplaced read-mux leg, appear on the first later read of the enable register or of an unmapped offset.

// File: rtl/intgrp_pkg.sv
package intgrp_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_SET  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'hC;

    typedef enum logic [1:0] {
        SEL_SET  = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        if (a == OFS_SET)       r = SEL_SET;
        else if (a == OFS_CLR)  r = SEL_CLR;
        else if (a == OFS_STAT) r = SEL_STAT;
        else                    r = SEL_NONE;
        return r;
    endfunction

endpackage

// File: rtl/intgrp_sync.sv
module intgrp_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] pipe;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        pipe[i] <= pipe[i-1];
                    end
                end
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/intgrp_regs.sv
module intgrp_regs
    import intgrp_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NSRC-1:0]   wdata,
    input  logic [NSRC-1:0]   stat,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   rdata
);
    reg_sel_e        sel;
    logic            do_wr;
    logic            do_rd;
    logic [NSRC-1:0] set_m;
    logic [NSRC-1:0] clr_m;
    logic [NSRC-1:0] rd_mux;

    always_comb begin
        sel   = decode_sel(req.addr);
        do_wr = req.sel && req.wr;
        do_rd = req.sel && !req.wr;
        set_m = (do_wr && sel == SEL_SET) ? wdata : '0;
        clr_m = (do_wr && sel == SEL_CLR) ? wdata : '0;
        case (sel)
            SEL_SET, SEL_CLR: rd_mux = en_q;
            SEL_STAT:         rd_mux = stat;
            default:          rd_mux = '0;
        endcase
    end

    // clear beats set when both masks hit one bit
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            rdata <= '0;
        end else begin
            en_q  <= (en_q | set_m) & ~clr_m;
            rdata <= do_rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/intgrp_group.sv
module intgrp_group #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] bits,
    output logic          grp_q
);
    always_ff @(posedge clk) begin
        if (rst) grp_q <= 1'b0;
        else     grp_q <= |bits;
    end
endmodule

// File: rtl/intgrp_combiner.sv
module intgrp_combiner
    import intgrp_pkg::*;
#(
    parameter int NGROUPS     = 4,
    parameter int GROUP_W     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NSRC       = NGROUPS * GROUP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic [NGROUPS-1:0] irq_out
);
    bus_req_t        req;
    logic [NSRC-1:0] sync_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] stat_w;

    assign req = '{sel: bus_sel, wr: bus_wr, addr: bus_addr};

    intgrp_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (sync_q)
    );

    intgrp_regs #(.NSRC(NSRC)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .wdata (bus_wdata),
        .stat  (stat_w),
        .en_q  (en_q),
        .rdata (bus_rdata)
    );

    assign stat_w = sync_q & en_q;

    generate
        for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
            intgrp_group #(.GW(GROUP_W)) u_grp (
                .clk   (clk),
                .rst   (rst),
                .bits  (stat_w[g*GROUP_W +: GROUP_W]),
                .grp_q (irq_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/intgrp_chk.sv
module intgrp_chk
    import intgrp_pkg::*;
#(
    parameter int NGROUPS = 4,
    parameter int GROUP_W = 8,
    localparam int NSRC   = NGROUPS * GROUP_W
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NSRC-1:0]    bus_wdata,
    input logic [NSRC-1:0]    bus_rdata,
    input logic [NGROUPS-1:0] irq_out,
    input logic [NSRC-1:0]    en,
    input logic [NSRC-1:0]    stat
);
    reg_sel_e s;
    logic     wr_set, wr_clr, rd_en, rd_stat, rd_none;
    logic     past_rst = 1'b0;

    always_comb begin
        s       = decode_sel(bus_addr);
        wr_set  = bus_sel && bus_wr && s == SEL_SET;
        wr_clr  = bus_sel && bus_wr && s == SEL_CLR;
        rd_en   = bus_sel && !bus_wr && (s == SEL_SET || s == SEL_CLR);
        rd_stat = bus_sel && !bus_wr && s == SEL_STAT;
        rd_none = bus_sel && !bus_wr && s == SEL_NONE;
    end

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (past_rst) begin
            a_r1_reset_state: assert (irq_out == '0 && en == '0 && bus_rdata == '0);
        end
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((en & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((en & $past(bus_wdata)) == '0));

    a_r8_other_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!wr_set && !wr_clr) |=> $stable(en));

    a_r4_enable_readback: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (bus_rdata == $past(en)));

    a_r5_status_readback: assert property (@(posedge clk) disable iff (rst)
        rd_stat |=> (bus_rdata == $past(stat)));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_none || !bus_sel || bus_wr) |=> (bus_rdata == '0));

    generate
        for (genvar g = 0; g < NGROUPS; g++) begin : g_or
            a_r7_group_or: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (irq_out[g] == |$past(stat[g*GROUP_W +: GROUP_W])));
        end
    endgenerate
endmodule

bind intgrp_combiner intgrp_chk #(.NGROUPS(NGROUPS), .GROUP_W(GROUP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en        (en_q),
    .stat      (stat_w)
);

// File: tb/sim_intgrp_combiner.sv
module sim_intgrp_combiner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [3:0]  irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit auto_on = 1'b0;
    bit finished = 1'b0;
    string rd_tag = "R8";

    // bench reference state, derived from the requirements
    logic [31:0] m_s1, m_s2, m_en, m_rd;
    logic [3:0]  m_grp;

    always #10 clk = ~clk;

    intgrp_combiner u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [3:0] f_grp(input logic [31:0] v);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |v[g*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] f_read(input logic [3:0] a, input logic [31:0] en,
                                           input logic [31:0] st);
        if (a == 4'h0 || a == 4'h4) return en;
        if (a == 4'hC) return st;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_en <= '0; m_rd <= '0; m_grp <= '0;
        end else begin
            m_s1  <= irq_in;
            m_s2  <= m_s1;
            m_grp <= f_grp(m_s2 & m_en);
            m_rd  <= (bus_sel && !bus_wr) ? f_read(bus_addr, m_en, m_s2 & m_en) : 32'h0;
            if (bus_sel && bus_wr && bus_addr == 4'h0) m_en <= m_en | bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 4'h4) m_en <= m_en & ~bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    always @(negedge clk) begin
        if (auto_on) begin
            chk("R7", {28'h0, irq_out}, {28'h0, m_grp});
            chk(rd_tag, bus_rdata, m_rd);
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        int unsigned op;
        seed = 32'h5eed_0042;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        chk("R1", {28'h0, irq_out}, 32'h0);
        chk("R1", bus_rdata, 32'h0);
        rst = 1'b0;
        chk("R1", {28'h0, irq_out}, 32'h0);
        bus_read(4'h0, d);       chk("R1", d, 32'h0);

        bus_write(4'h0, 32'h0000_00A5);
        bus_read(4'h0, d);       chk("R2", d, 32'h0000_00A5);
        bus_write(4'h0, 32'h0000_0F00);
        bus_read(4'h0, d);       chk("R2", d, 32'h0000_0FA5);
        bus_write(4'h4, 32'h0000_0081);
        bus_read(4'h0, d);       chk("R3", d, 32'h0000_0F24);
        bus_read(4'h4, d);       chk("R4", d, 32'h0000_0F24);

        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h0, d);       chk("R8", d, 32'h0000_0F24);
        bus_read(4'h8, d);       chk("R8", d, 32'h0);

        irq_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        bus_read(4'hC, d);       chk("R5", d, 32'h0000_0F24);
        chk("R9", {28'h0, irq_out}, 32'h3);
        irq_in = 32'h0000_0104;
        repeat (4) @(negedge clk);
        bus_read(4'hC, d);       chk("R5", d, 32'h0000_0104);
        chk("R9", {28'h0, irq_out}, 32'h3);
        irq_in = 32'h0000_0100;
        repeat (4) @(negedge clk);
        chk("R9", {28'h0, irq_out}, 32'h2);

        irq_in = 32'h0;
        repeat (4) @(negedge clk);
        bus_read(4'hC, d);       chk("R6", d, 32'h0);
        chk("R6", {28'h0, irq_out}, 32'h0);

        bus_write(4'h0, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        irq_in = 32'h0002_0000;
        @(negedge clk);          chk("R7", {28'h0, irq_out}, 32'h0);
        @(negedge clk);          chk("R7", {28'h0, irq_out}, 32'h0);
        @(negedge clk);          chk("R7", {28'h0, irq_out}, 32'h4);
        irq_in = 32'h0;
        repeat (3) @(negedge clk);
        chk("R6", {28'h0, irq_out}, 32'h0);

        auto_on = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            irq_in = $urandom();
            op = $urandom_range(0, 9);
            bus_addr = 4'(($urandom_range(0, 3)) * 4);
            if ($urandom_range(0, 15) == 0) bus_addr = 4'($urandom_range(0, 15));
            bus_wdata = $urandom() & $urandom();
            bus_sel = (op < 6);
            bus_wr = (op < 3);
            if (bus_sel && !bus_wr) begin
                if (bus_addr == 4'hC) rd_tag = "R5";
                else if (bus_addr == 4'h0 || bus_addr == 4'h4) rd_tag = "R4";
                else rd_tag = "R8";
            end else begin
                rd_tag = "R8";
            end
            @(negedge clk);
        end
        auto_on = 1'b0;

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule